// File: doc/BRIEF.md
# Command-Byte Global Register Interface

This block sits behind a byte-wide control port and turns a stream of command and data bytes into accesses to a handful of chip-wide registers. Every transfer starts with a command byte. Its top bit gives the direction and its low seven bits give the register address. A write command is followed by one data byte from the host. A read command is answered by the block, which puts one byte on a separate read-data output during the cycle after the command is taken.

The register set is small. There is a constant version register and a six-bit clock-selection register that can be read and written. Four write-only addresses also exist. One of them does nothing. The other three raise a single-cycle pulse to clear interrupts, reset local state, or reset the whole chip, but only when the data byte is all ones. The clock-selection value drives two frequency-select fields used by clock generators downstream. A whole-chip reset returns that value to zero, which means both generated clocks are held high. A local reset leaves it untouched.

Top module: `greg_cmd_if`

## Requirements
- R1: While reset is applied and in the first cycle after it, `byte_ready_o` is 1, `rd_valid_o` is 0, all three pulse outputs are 0, and both select fields are 0.
- R2: A byte with bit 7 = 0 that is accepted as a command is a read. The cycle after acceptance has `rd_valid_o` = 1 and `byte_ready_o` = 0, and both return to 1/0 respectively a cycle later. For address 20H the read data equals the version parameter (default 01H).
- R3: A read of address 24H returns bits [5:4] = fast select and bits [3:0] = slow select, with bits [7:6] read as 0.
- R4: A read of any address other than 20H and 24H returns 00H.
- R5: Command A4H followed by a data byte D loads the fast select with D[5:4] and the slow select with D[3:0]. The new values are visible in the cycle after D is accepted. D[7:6] have no effect.
- R6: Command A1H followed by FFH raises `irq_clear_o` for exactly one cycle, the cycle after the data byte is accepted.
- R7: Command A2H followed by FFH raises `local_reset_o` for exactly one cycle (the cycle after the data byte is accepted). Both select fields stay unchanged.
- R8: Command A3H followed by FFH raises `chip_reset_o` and `local_reset_o` together for one cycle. In that same cycle both select fields read 0.
- R9: When the data byte after A1H, A2H or A3H is anything other than FFH, it is consumed with no pulse and no change to the select fields.
- R10: Command A0H, or any write command whose address is not A1H–A4H, consumes its data byte and has no visible effect.
- R11: Bytes offered while `byte_valid_i` is 0 are ignored. A write command stays pending across any number of such idle cycles until its data byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | Host byte is present |
| byte_data_i | input | 8 | Command or write-data byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| rd_valid_o | output | 1 | Read response present this cycle |
| rd_data_o | output | 8 | Read response byte |
| irq_clear_o | output | 1 | One-cycle interrupt-clear pulse |
| local_reset_o | output | 1 | One-cycle request to reset local registers |
| chip_reset_o | output | 1 | One-cycle whole-chip reset pulse |
| fast_sel_o | output | 2 | Fast clock frequency select |
| slow_sel_o | output | 4 | Slow clock frequency select |

## Verification
The decoder is exercised with directed sequences and with random traffic. Each strobe address is tried with FFH and with a near-miss data byte, which separates a check on the full byte from a check on only some of its bits. Clock-select writes use data whose reserved bits are set, and then a read-back, which exposes any leak of bits 7:6. Random command bytes cover read addresses across the full seven-bit range and write addresses outside the defined set, with idle gaps carrying junk data placed between the bytes of a transfer. These gaps show whether a pending write survives a gap and whether invalid bytes are ignored.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int NUM_STROBE = 3;

  localparam logic [ADDR_W-1:0] A_VERSION = 7'h20;
  localparam logic [ADDR_W-1:0] A_NOP     = 7'h20;
  localparam logic [ADDR_W-1:0] A_IRQCLR  = 7'h21;
  localparam logic [ADDR_W-1:0] A_LOCRST  = 7'h22;
  localparam logic [ADDR_W-1:0] A_CHIPRST = 7'h23;
  localparam logic [ADDR_W-1:0] A_CLKSEL  = 7'h24;

  // strobe slot indices
  localparam int S_IRQ  = 0;
  localparam int S_LOC  = 1;
  localparam int S_CHIP = 2;

  typedef enum logic [1:0] {
    PS_CMD  = 2'd0,
    PS_DATA = 2'd1,
    PS_RESP = 2'd2
  } parse_st_e;

  function automatic logic [ADDR_W-1:0] strobe_addr(input int idx);
    case (idx)
      S_IRQ:   return A_IRQCLR;
      S_LOC:   return A_LOCRST;
      default: return A_CHIPRST;
    endcase
  endfunction

  function automatic logic all_ones(input logic [BYTE_W-1:0] d);
    return &d;
  endfunction

  function automatic logic is_write_cmd(input logic [BYTE_W-1:0] d);
    return d[BYTE_W-1];
  endfunction

endpackage

// File: rtl/greg_parser.sv
module greg_parser
  import gcr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_valid_i,
  input  logic [BYTE_W-1:0]    byte_data_i,
  output logic                 byte_ready_o,
  output logic                 rd_fire_o,
  output logic [ADDR_W-1:0]    rd_addr_o,
  output logic                 wr_fire_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0]    wr_data_o
);

  parse_st_e          state_q, state_d;
  logic [ADDR_W-1:0]  cmd_addr_q;
  logic               accept;

  assign byte_ready_o = (state_q != PS_RESP);
  assign accept       = byte_valid_i && byte_ready_o;

  assign rd_fire_o = accept && (state_q == PS_CMD) && !is_write_cmd(byte_data_i);
  assign rd_addr_o = byte_data_i[ADDR_W-1:0];
  assign wr_fire_o = accept && (state_q == PS_DATA);
  assign wr_addr_o = cmd_addr_q;
  assign wr_data_o = byte_data_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_CMD: begin
        if (accept) state_d = is_write_cmd(byte_data_i) ? PS_DATA : PS_RESP;
      end
      PS_DATA: begin
        if (accept) state_d = PS_CMD;
      end
      default: state_d = PS_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_CMD;
      cmd_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept && (state_q == PS_CMD)) cmd_addr_q <= byte_data_i[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/greg_regs.sv
module greg_regs
  import gcr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] VERSION_VAL = 8'h01,
  parameter int FAST_W = 2,
  parameter int SLOW_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_fire_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic                 wr_fire_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  input  logic                 chip_clear_i,
  output logic                 rd_valid_o,
  output logic [BYTE_W-1:0]    rd_data_o,
  output logic [FAST_W-1:0]    fast_sel_o,
  output logic [SLOW_W-1:0]    slow_sel_o
);

  localparam int SEL_W = FAST_W + SLOW_W;

  logic [SEL_W-1:0]  sel_q;
  logic              sel_write;
  logic [BYTE_W-1:0] rd_value;
  logic              rd_valid_q;
  logic [BYTE_W-1:0] rd_data_q;

  assign sel_write = wr_fire_i && (wr_addr_i == A_CLKSEL);

  always_comb begin
    case (rd_addr_i)
      A_VERSION: rd_value = VERSION_VAL;
      A_CLKSEL:  rd_value = BYTE_W'(sel_q);
      default:   rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (chip_clear_i)   sel_q <= '0;
      else if (sel_write) sel_q <= wr_data_i[SEL_W-1:0];
      rd_valid_q <= rd_fire_i;
      if (rd_fire_i) rd_data_q <= rd_value;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign fast_sel_o = sel_q[SEL_W-1:SLOW_W];
  assign slow_sel_o = sel_q[SLOW_W-1:0];

endmodule

// File: rtl/greg_strobes.sv
module greg_strobes
  import gcr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  output logic [NUM_STROBE-1:0] hit_o,
  output logic [NUM_STROBE-1:0] pulse_o
);

  for (genvar i = 0; i < NUM_STROBE; i++) begin : g_strobe
    logic pulse_q;
    assign hit_o[i] = wr_fire_i && (wr_addr_i == strobe_addr(i)) && all_ones(wr_data_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit_o[i];
    end
    assign pulse_o[i] = pulse_q;
  end

endmodule

// File: rtl/greg_cmd_if.sv
module greg_cmd_if
  import gcr_pkg::*;
#(
  parameter logic [7:0] VERSION_VAL = 8'h01,
  parameter int FAST_W = 2,
  parameter int SLOW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              irq_clear_o,
  output logic              local_reset_o,
  output logic              chip_reset_o,
  output logic [FAST_W-1:0] fast_sel_o,
  output logic [SLOW_W-1:0] slow_sel_o
);

  // internal events, named for the checker
  logic                  rd_fire;
  logic [ADDR_W-1:0]     rd_addr;
  logic                  wr_fire;
  logic [ADDR_W-1:0]     wr_addr;
  logic [BYTE_W-1:0]     wr_data;
  logic [NUM_STROBE-1:0] strobe_hit;
  logic [NUM_STROBE-1:0] strobe_pulse;

  greg_parser u_parser (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .byte_data_i  (byte_data_i),
    .byte_ready_o (byte_ready_o),
    .rd_fire_o    (rd_fire),
    .rd_addr_o    (rd_addr),
    .wr_fire_o    (wr_fire),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data)
  );

  greg_strobes u_strobes (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire_i (wr_fire),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .hit_o     (strobe_hit),
    .pulse_o   (strobe_pulse)
  );

  greg_regs #(
    .VERSION_VAL (VERSION_VAL),
    .FAST_W      (FAST_W),
    .SLOW_W      (SLOW_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_fire_i    (rd_fire),
    .rd_addr_i    (rd_addr),
    .wr_fire_i    (wr_fire),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .chip_clear_i (strobe_hit[S_CHIP]),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .fast_sel_o   (fast_sel_o),
    .slow_sel_o   (slow_sel_o)
  );

  assign irq_clear_o   = strobe_pulse[S_IRQ];
  assign chip_reset_o  = strobe_pulse[S_CHIP];
  assign local_reset_o = strobe_pulse[S_LOC] | strobe_pulse[S_CHIP];

endmodule

// File: rtl/greg_cmd_if_chk.sv
module greg_cmd_if_chk
  import gcr_pkg::*;
#(
  parameter logic [7:0] VERSION_VAL = 8'h01,
  parameter int FAST_W = 2,
  parameter int SLOW_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_ready_o,
  input logic              rd_valid_o,
  input logic [7:0]        rd_data_o,
  input logic              irq_clear_o,
  input logic              local_reset_o,
  input logic              chip_reset_o,
  input logic [FAST_W-1:0] fast_sel_o,
  input logic [SLOW_W-1:0] slow_sel_o,
  input logic              rd_fire,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_fire,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data
);

  localparam int SEL_W = FAST_W + SLOW_W;

  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rd_valid_o && !byte_ready_o));

  p_read_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);

  p_version_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_addr == A_VERSION) |=> (rd_data_o == VERSION_VAL));

  p_undef_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_addr != A_VERSION && rd_addr != A_CLKSEL) |=> (rd_data_o == 8'h00));

  p_sel_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == A_CLKSEL) |=> ({fast_sel_o, slow_sel_o} == $past(wr_data[SEL_W-1:0])));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear_o |=> !irq_clear_o);

  p_local_keeps_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (local_reset_o && !chip_reset_o) |-> $stable({fast_sel_o, slow_sel_o}));

  p_chip_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_reset_o |-> (local_reset_o && fast_sel_o == '0 && slow_sel_o == '0));

  p_strobe_needs_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear_o || local_reset_o) |-> $past(wr_fire && (&wr_data)));

endmodule

bind greg_cmd_if greg_cmd_if_chk #(
  .VERSION_VAL (VERSION_VAL),
  .FAST_W      (FAST_W),
  .SLOW_W      (SLOW_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_ready_o  (byte_ready_o),
  .rd_valid_o    (rd_valid_o),
  .rd_data_o     (rd_data_o),
  .irq_clear_o   (irq_clear_o),
  .local_reset_o (local_reset_o),
  .chip_reset_o  (chip_reset_o),
  .fast_sel_o    (fast_sel_o),
  .slow_sel_o    (slow_sel_o),
  .rd_fire       (rd_fire),
  .rd_addr       (rd_addr),
  .wr_fire       (wr_fire),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data)
);

// File: tb/greg_cmd_if_tb_top.sv
`timescale 1ns/1ps
module greg_cmd_if_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       byte_ready, rd_valid, irq_clr, loc_rst, chip_rst;
  logic [7:0] rd_data;
  logic [1:0] fast_sel;
  logic [3:0] slow_sel;

  int checks = 0;
  int fails  = 0;
  logic [1:0] m_fast = 2'b00;
  logic [3:0] m_slow = 4'h0;

  always #2 clk = ~clk;

  greg_cmd_if dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid_i  (byte_valid),
    .byte_data_i   (byte_data),
    .byte_ready_o  (byte_ready),
    .rd_valid_o    (rd_valid),
    .rd_data_o     (rd_data),
    .irq_clear_o   (irq_clr),
    .local_reset_o (loc_rst),
    .chip_reset_o  (chip_rst),
    .fast_sel_o    (fast_sel),
    .slow_sel_o    (slow_sel)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] a, input logic [1:0] f, input logic [3:0] s);
    if (a == 7'h20) return 8'h01;
    if (a == 7'h24) return {2'b00, f, s};
    return 8'h00;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(posedge clk);
    #1;
    byte_valid = 1'b0;
    byte_data  = 8'($urandom);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_valid = 1'b0;
      byte_data  = 8'($urandom);
    end
  endtask

  task automatic do_read(input logic [7:0] cmd, input string req);
    logic [7:0] e;
    e = exp_read(cmd[6:0], m_fast, m_slow);
    put(cmd);
    @(negedge clk);
    chk(rd_valid && !byte_ready, {req, " R2 resp/ready"}, {rd_valid, byte_ready}, 2'b10);
    chk(rd_data == e, req, rd_data, e);
    @(negedge clk);
    chk(!rd_valid && byte_ready, "R2 resp ends", {rd_valid, byte_ready}, 2'b01);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [7:0] d, input int gap, input string req);
    logic ones, e_irq, e_loc, e_chip;
    ones   = (d == 8'hFF);
    e_irq  = (cmd == 8'hA1) && ones;
    e_loc  = (cmd == 8'hA2 || cmd == 8'hA3) && ones;
    e_chip = (cmd == 8'hA3) && ones;
    put(cmd);
    if (gap > 0) idle(gap);
    put(d);
    if (cmd == 8'hA4) begin
      m_fast = d[5:4];
      m_slow = d[3:0];
    end
    if (e_chip) begin
      m_fast = 2'b00;
      m_slow = 4'h0;
    end
    @(negedge clk);
    chk({irq_clr, loc_rst, chip_rst} == {e_irq, e_loc, e_chip}, req,
        {irq_clr, loc_rst, chip_rst}, {e_irq, e_loc, e_chip});
    chk({fast_sel, slow_sel} == {m_fast, m_slow}, {req, " select"},
        {fast_sel, slow_sel}, {m_fast, m_slow});
    @(negedge clk);
    chk({irq_clr, loc_rst, chip_rst} == 3'b000, {req, " pulse one cycle"},
        {irq_clr, loc_rst, chip_rst}, 3'b000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    repeat (3) @(negedge clk);
    chk(byte_ready && !rd_valid && !irq_clr && !loc_rst && !chip_rst && fast_sel == 0 && slow_sel == 0,
        "R1 in reset", {byte_ready, rd_valid, irq_clr, loc_rst, chip_rst, fast_sel, slow_sel}, 11'h400);
    rst_n = 1'b1;
    @(negedge clk);
    chk(byte_ready && !rd_valid && fast_sel == 0 && slow_sel == 0, "R1 after reset",
        {byte_ready, rd_valid, fast_sel, slow_sel}, 8'h80);

    // directed corner cases
    do_read(8'h20, "R2 version");
    do_read(8'h24, "R3 select default");
    do_read(8'h21, "R4 undefined read");
    do_read(8'h7F, "R4 undefined read top");
    do_write(8'hA4, 8'hC5, 0, "R5 reserved bits ignored");
    do_read(8'h24, "R3 select readback");
    do_write(8'hA4, 8'h3A, 0, "R5 select write");
    do_read(8'h24, "R3 select readback 2");
    do_write(8'hA2, 8'hFF, 0, "R7 local reset");
    do_write(8'hA1, 8'hFF, 0, "R6 irq clear");
    do_write(8'hA1, 8'hFE, 0, "R9 irq near miss");
    do_write(8'hA2, 8'h7F, 0, "R9 local near miss");
    do_write(8'hA3, 8'hEF, 0, "R9 chip near miss");
    do_write(8'hA0, 8'hFF, 0, "R10 no-op write");
    do_write(8'hA0, 8'h00, 0, "R10 no-op write zero");
    do_write(8'hA5, 8'hFF, 0, "R10 undefined write");
    do_write(8'hA3, 8'hFF, 0, "R8 chip reset");
    do_read(8'h24, "R8 select cleared");
    do_write(8'hA4, 8'h12, 5, "R11 pending across idle");
    do_read(8'h24, "R11 readback after gap");

    // constrained random traffic
    for (int i = 0; i < 300; i++) begin
      int kind;
      logic [7:0] cmd, d;
      kind = int'($urandom_range(0, 9));
      d = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
      if (kind < 3) begin
        cmd = (kind == 0) ? 8'h20 : (kind == 1) ? 8'h24 : {1'b0, 7'($urandom)};
        do_read(cmd, "R4 random read");
      end else if (kind < 8) begin
        cmd = 8'hA0 + 8'(kind - 3);
        if (cmd == 8'hA3 && $urandom_range(0, 3) != 0) d = 8'hFE;
        do_write(cmd, d, int'($urandom_range(0, 3)), "R9 random write");
      end else begin
        cmd = {1'b1, 7'($urandom)};
        do_write(cmd, d, int'($urandom_range(0, 2)), "R10 random write");
      end
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule